// File: doc/BRIEF.md
# Shifter Operand Evaluation Unit

This block produces the second source operand of a 32-bit data-processing instruction, together with the carry that the shifter passes to the flag logic. It receives the instruction word, the values already read for the shifted register and the amount register, and the current carry flag. From these it forms one of two operands. The first is an 8-bit constant rotated right by an even amount. The second is the shifted register value, moved by a logical, arithmetic or rotate shift. The shift amount comes either from a 5-bit field in the instruction or from the low byte of the amount register.

An input register stage captures the request. The shifter and rotator logic between the two stages is combinational, and an output register stage presents the result. The surrounding pipeline reads the register file, and it consumes the operand and carry in its ALU and flag writeback.

Top module: `shift_operand_unit`

## Requirements
- R1: Instruction bit 25 selects the operand form: 1 gives the rotated immediate (R2), 0 gives the shifted register (R3..R8).
- R2: The immediate operand is instr[7:0] zero-extended and rotated right by twice instr[11:8]. The carry out is carry_in when instr[11:8] is 0, and otherwise operand bit 31.
- R3: instr[6:4] is the shift code. The kind is taken from code bits 2:1 (0 left-logical, 1 right-logical, 2 right-arithmetic, 3 rotate right). An even code takes its amount from instr[11:7] and an odd code from rs_val[7:0]. A nonzero shift returns the shifted rm_val, and the carry out is the last bit shifted out.
- R4: Code 0 with an immediate amount of 0 returns rm_val unchanged, and carry_in is passed through as the carry.
- R5: Codes 2 and 4 with an immediate amount of 0 shift by 32. Code 2 gives 0, and code 4 fills every bit with rm_val[31]. Both give rm_val[31] as carry.
- R6: Code 6 with an immediate amount of 0 rotates right by one through the carry: the operand is {carry_in, rm_val[31:1]} and the carry is rm_val[0].
- R7: An odd code with rs_val[7:0] equal to 0 returns rm_val and carry_in unchanged.
- R8: Register amounts of 32 or more behave as follows. For codes 1 and 3, an amount of exactly 32 gives 0 with carry rm_val[0] (code 1) or rm_val[31] (code 3), and a larger amount gives 0 with carry 0. Code 5 fills every bit with rm_val[31] and gives carry rm_val[31]. Code 7 rotates by the amount modulo 32; when that remainder is 0 it returns rm_val with carry rm_val[31].
- R9: A request accepted with in_valid at rising edge k drives out_valid high, with its operand and carry, after edge k+1. out_valid is low in every other cycle.
- R10: During reset, out_valid, operand and carry_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register to be shifted |
| rs_val | input | 32 | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Every stage is a plain register, so a corrupted field or a wrong decoded kind shows on operand or carry_out in the same cycle that out_valid rises for that request. The zero-amount encodings are checked directly at the ports, along with the boundary amounts 1, 31, 32, 33 and 255 for all eight shift codes. Any error in the amount decode or the big-shift saturation therefore appears as a wrong value or carry on the next result. A stage-valid fault appears as out_valid in the wrong cycle.

// File: rtl/sop_pkg.sv
package sop_pkg;
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   localparam int FORM_BIT   = 25;
   localparam int FIELD_W    = 12;
   localparam int IMM8_W     = 8;
   localparam int ROT4_W     = 4;
   localparam int SHAMT_W    = 5;
   localparam int CODE_W     = 3;
endpackage

// File: rtl/sop_rotr.sv
module sop_rotr #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   if (W < 2 || (1 << AW) != W) begin : g_chk
      $error("sop_rotr: W must be a power of two matching AW");
   end

   logic [W-1:0] stg [0:AW];
   assign stg[0] = din;

   for (genvar s = 0; s < AW; s++) begin : g_stage
      localparam int K = 1 << s;
      assign stg[s+1] = amt[s] ? {stg[s][K-1:0], stg[s][W-1:K]} : stg[s];
   end

   assign dout = stg[AW];
endmodule

// File: rtl/sop_imm_rot.sv
module sop_imm_rot #(
   parameter int W = 32
) (
   input  logic [sop_pkg::IMM8_W-1:0] imm8,
   input  logic [sop_pkg::ROT4_W-1:0] rot4,
   input  logic                        cin,
   output logic [W-1:0]                res,
   output logic                        cout
);
   localparam int AW = $clog2(W);

   if (AW < sop_pkg::ROT4_W + 1) begin : g_chk
      $error("sop_imm_rot: W too narrow for the rotate field");
   end

   logic [AW-1:0] rot_amt;
   logic [W-1:0]  base;

   assign rot_amt = AW'({rot4, 1'b0});
   assign base    = W'(imm8);

   sop_rotr #(.W(W), .AW(AW)) u_rot (
      .din  (base),
      .amt  (rot_amt),
      .dout (res)
   );

   assign cout = (rot4 == '0) ? cin : res[W-1];
endmodule

// File: rtl/sop_amt_dec.sv
module sop_amt_dec
   import sop_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [CODE_W-1:0]  code,
   input  logic [SHAMT_W-1:0] imm_amt,
   input  logic [AMT_W-1:0]   reg_amt,
   output shift_kind_e        kind,
   output logic [AMT_W-1:0]   amt,
   output logic               keep
);
   if (AMT_W <= $clog2(W)) begin : g_chk
      $error("sop_amt_dec: AMT_W must hold the value W");
   end

   shift_kind_e base_kind;

   always_comb begin
      unique case (code[2:1])
         2'd0:    base_kind = SK_LSL;
         2'd1:    base_kind = SK_LSR;
         2'd2:    base_kind = SK_ASR;
         default: base_kind = SK_ROR;
      endcase
   end

   always_comb begin
      kind = base_kind;
      amt  = AMT_W'(imm_amt);
      keep = 1'b0;
      if (code[0]) begin
         amt  = reg_amt;
         keep = (reg_amt == '0);
      end else if (imm_amt == '0) begin
         unique case (base_kind)
            SK_LSL:  keep = 1'b1;
            SK_ROR:  kind = SK_RRX;
            default: amt  = AMT_W'(W);
         endcase
      end
   end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
   import sop_pkg::*;
#(
   parameter int W     = 32,
   parameter int AMT_W = 8
) (
   input  logic [W-1:0]     din,
   input  shift_kind_e      kind,
   input  logic [AMT_W-1:0] amt,
   input  logic             keep,
   input  logic             cin,
   output logic [W-1:0]     res,
   output logic             cout
);
   localparam int LW = $clog2(W);

   logic [LW-1:0] low;
   logic          big;
   logic          exact;
   logic [W:0]    lsl_t;
   logic [W:0]    lsr_t;
   logic [W:0]    asr_t;
   logic [W-1:0]  ror_r;

   assign low   = amt[LW-1:0];
   assign big   = (amt >= AMT_W'(W));
   assign exact = (amt == AMT_W'(W));

   assign lsl_t = {1'b0, din} << low;
   assign lsr_t = {din, 1'b0} >> low;
   assign asr_t = $unsigned($signed({din, 1'b0}) >>> low);

   sop_rotr #(.W(W), .AW(LW)) u_ror (
      .din  (din),
      .amt  (low),
      .dout (ror_r)
   );

   always_comb begin
      res  = din;
      cout = cin;
      if (!keep) begin
         unique case (kind)
            SK_LSL: begin
               if (big) begin
                  res  = '0;
                  cout = exact ? din[0] : 1'b0;
               end else begin
                  res  = lsl_t[W-1:0];
                  cout = lsl_t[W];
               end
            end
            SK_LSR: begin
               if (big) begin
                  res  = '0;
                  cout = exact ? din[W-1] : 1'b0;
               end else begin
                  res  = lsr_t[W:1];
                  cout = lsr_t[0];
               end
            end
            SK_ASR: begin
               if (big) begin
                  res  = {W{din[W-1]}};
                  cout = din[W-1];
               end else begin
                  res  = asr_t[W:1];
                  cout = asr_t[0];
               end
            end
            SK_ROR: begin
               res  = ror_r;
               cout = ror_r[W-1];
            end
            default: begin
               res  = {cin, din[W-1:1]};
               cout = din[0];
            end
         endcase
      end
   end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
   import sop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] rm_val,
   input  logic [DATA_W-1:0] rs_val,
   input  logic              carry_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] operand,
   output logic              carry_out
);
   if (DATA_W != 32) begin : g_chk_w
      $error("shift_operand_unit: field layout needs DATA_W == 32");
   end
   if (AMT_W > DATA_W) begin : g_chk_a
      $error("shift_operand_unit: AMT_W exceeds DATA_W");
   end

   logic unused_in_bits;
   assign unused_in_bits = ^{instr[31:FORM_BIT+1], instr[FORM_BIT-1:FIELD_W],
                             rs_val[DATA_W-1:AMT_W]};

   // input stage
   logic               v_q;
   logic               sel_q;
   logic [FIELD_W-1:0] fld_q;
   logic [DATA_W-1:0]  rm_q;
   logic [AMT_W-1:0]   rs_q;
   logic               cin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         sel_q <= 1'b0;
         fld_q <= '0;
         rm_q  <= '0;
         rs_q  <= '0;
         cin_q <= 1'b0;
      end else begin
         v_q <= in_valid;
         if (in_valid) begin
            sel_q <= instr[FORM_BIT];
            fld_q <= instr[FIELD_W-1:0];
            rm_q  <= rm_val;
            rs_q  <= rs_val[AMT_W-1:0];
            cin_q <= carry_in;
         end
      end
   end

   // operand paths
   logic [DATA_W-1:0] imm_res;
   logic              imm_c;
   shift_kind_e       kind;
   logic [AMT_W-1:0]  amt;
   logic              keep;
   logic [DATA_W-1:0] sh_res;
   logic              sh_c;

   sop_imm_rot #(.W(DATA_W)) u_imm (
      .imm8 (fld_q[IMM8_W-1:0]),
      .rot4 (fld_q[FIELD_W-1:IMM8_W]),
      .cin  (cin_q),
      .res  (imm_res),
      .cout (imm_c)
   );

   sop_amt_dec #(.W(DATA_W), .AMT_W(AMT_W)) u_dec (
      .code    (fld_q[6:4]),
      .imm_amt (fld_q[11:7]),
      .reg_amt (rs_q),
      .kind    (kind),
      .amt     (amt),
      .keep    (keep)
   );

   sop_barrel #(.W(DATA_W), .AMT_W(AMT_W)) u_sh (
      .din  (rm_q),
      .kind (kind),
      .amt  (amt),
      .keep (keep),
      .cin  (cin_q),
      .res  (sh_res),
      .cout (sh_c)
   );

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         operand   <= '0;
         carry_out <= 1'b0;
      end else begin
         out_valid <= v_q;
         if (v_q) begin
            operand   <= sel_q ? imm_res : sh_res;
            carry_out <= sel_q ? imm_c   : sh_c;
         end
      end
   end

   // assertions
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      v_q |=> out_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q |=> !out_valid);
   a_r2_imm_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && sel_q) |=> ($countones(operand) <= IMM8_W));
   a_r2_imm_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && sel_q && fld_q[11:8] == '0) |=> (carry_out == $past(cin_q)));
   a_r6_rrx: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && !sel_q && fld_q[6:4] == 3'd6 && fld_q[11:7] == '0)
      |=> (operand[DATA_W-1] == $past(cin_q) && carry_out == $past(rm_q[0])));
   a_r7_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && !sel_q && fld_q[4] && rs_q == '0)
      |=> (operand == $past(rm_q) && carry_out == $past(cin_q)));
   a_r8_big_logical: assert property (@(posedge clk) disable iff (!rst_n)
      (v_q && !sel_q && (fld_q[6:4] == 3'd1 || fld_q[6:4] == 3'd3) && rs_q > AMT_W'(DATA_W))
      |=> (operand == '0 && !carry_out));
endmodule

// File: tb/shift_operand_unit_tb.sv
module shift_operand_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] instr;
   logic [31:0] rm_val;
   logic [31:0] rs_val;
   logic        carry_in;
   logic        out_valid;
   logic [31:0] operand;
   logic        carry_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   shift_operand_unit dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .instr (instr),
      .rm_val (rm_val), .rs_val (rs_val), .carry_in (carry_in),
      .out_valid (out_valid), .operand (operand), .carry_out (carry_out)
   );

   // bit-serial model: carry is the last bit moved out
   function automatic logic [32:0] model(logic [31:0] ins, logic [31:0] rm,
                                         logic [31:0] rs, logic c);
      logic [31:0] v;
      logic [2:0]  code;
      int          a;
      if (ins[25]) begin
         v = {24'd0, ins[7:0]};
         for (int i = 0; i < 2 * ins[11:8]; i++) v = {v[0], v[31:1]};
         return {(ins[11:8] == 0) ? c : v[31], v};
      end
      code = ins[6:4];
      a    = code[0] ? int'(rs[7:0]) : int'(ins[11:7]);
      v    = rm;
      if (a == 0) begin
         if (code[0] || code == 3'd0) return {c, rm};
         if (code == 3'd2) return {rm[31], 32'd0};
         if (code == 3'd4) return {rm[31], {32{rm[31]}}};
         return {rm[0], c, rm[31:1]};
      end
      for (int i = 0; i < a; i++) begin
         case (code[2:1])
            2'd0:    begin c = v[31]; v = {v[30:0], 1'b0}; end
            2'd1:    begin c = v[0];  v = {1'b0, v[31:1]}; end
            2'd2:    begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0];  v = {v[0], v[31:1]}; end
         endcase
      end
      return {c, v};
   endfunction

   function automatic string tag_of(logic [31:0] ins, logic [31:0] rs);
      logic [2:0] code;
      code = ins[6:4];
      if (ins[25]) return "R2";
      if (!code[0] && ins[11:7] == 0) begin
         if (code == 3'd0) return "R4";
         if (code == 3'd6) return "R6";
         return "R5";
      end
      if (code[0] && rs[7:0] == 0) return "R7";
      if (code[0] && rs[7:0] >= 32) return "R8";
      return "R3";
   endfunction

   task automatic check(string req, logic [32:0] got, logic [32:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run_op(logic [31:0] ins, logic [31:0] rm, logic [31:0] rs,
                         logic c, string req);
      logic [32:0] exp;
      exp = model(ins, rm, rs, c);
      @(negedge clk);
      instr = ins; rm_val = rm; rs_val = rs; carry_in = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", {32'd0, out_valid}, 33'd0);
      @(negedge clk);
      check("R9", {32'd0, out_valid}, 33'd1);
      check(req, {carry_out, operand}, exp);
   endtask

   function automatic logic [31:0] mk_reg(int code, int amt5, logic flip);
      return 32'hE1A00000 | ((amt5 & 31) << 7) | ((code & 7) << 4) | (flip ? 32'h0 : 32'h3);
   endfunction

   initial begin
      int corner [6] = '{0, 1, 31, 32, 33, 255};
      logic [31:0] pats [3] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hC35A_0F96};
      logic [31:0] ins;
      process::self().srandom(32'd1234);
      rst_n = 1'b0; in_valid = 1'b0; instr = '0; rm_val = '0; rs_val = '0; carry_in = 1'b0;
      repeat (3) @(negedge clk);
      check("R10", {carry_out, operand}, 33'd0);
      check("R10", {32'd0, out_valid}, 33'd0);
      rst_n = 1'b1;

      // R1: same low bits, form bit toggled
      run_op(32'hE1A00C45, 32'h1234_5678, 32'd4, 1'b1, "R1");
      run_op(32'hE3A00C45, 32'h1234_5678, 32'd4, 1'b1, "R1");
      // R2 immediates
      run_op(32'hE3A000FF, 32'h0, 32'h0, 1'b1, "R2");
      run_op(32'hE3A000FF, 32'h0, 32'h0, 1'b0, "R2");
      run_op(32'hE3A001FF, 32'h0, 32'h0, 1'b0, "R2");
      run_op(32'hE3A00F81, 32'h0, 32'h0, 1'b0, "R2");
      run_op(32'hE3A00401, 32'h0, 32'h0, 1'b1, "R2");

      // every code at the corner amounts
      for (int code = 0; code < 8; code++)
         for (int k = 0; k < 6; k++)
            for (int p = 0; p < 3; p++) begin
               ins = mk_reg(code, corner[k], p[0]);
               run_op(ins, pats[p], {24'hABCDEF, 8'(corner[k])}, p[1],
                      tag_of(ins, {24'd0, 8'(corner[k])}));
            end

      // constrained random
      for (int n = 0; n < 600; n++) begin
         logic [31:0] rs;
         int sel;
         ins = $urandom;
         rs  = $urandom;
         sel = $urandom_range(0, 7);
         if (sel < 6) rs[7:0] = 8'(corner[sel]);
         run_op(ins, $urandom, rs, 1'($urandom), tag_of(ins, rs));
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R9: watchdog expired, got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule